// File: doc/BRIEF.md
# Self-Triggered Waveform Snippet Capture

This block watches one continuously sampled ADC channel and passes on only the parts of the waveform around activity. Any sample strictly above a programmable threshold arms the channel. The exported region starts a set number of samples before the first such sample. It runs on until a set number of samples after the last one. The region is also cut into pieces no longer than a programmable maximum. Each exported piece is framed as one header word followed by its samples. The header carries the index of the first sample, the channel number, the piece length and a flag that marks a piece which carries on directly from the one before.

Samples enter with a valid strobe. Cycles without the strobe are not samples and do not advance the time tag. A history ring delays the stream by the pre-trigger count, so the keep decision for each delayed sample is known as soon as it is read. The output is a valid/ready stream drawn from an internal FIFO. The header slot is reserved when a piece opens and filled when it closes. A sample that finds no room is dropped, and a sticky overflow flag is set. A typical setting is 32 samples before and 32 after. The settings are held constant between resets.

Top module: `snippet_capture`

## Requirements
- R1: A sample arms the channel only when it is strictly greater than `threshold`, compared as unsigned. A sample equal to the threshold exports nothing.
- R2: A piece starts `pre_len` samples before the first sample above threshold. If fewer samples have arrived since reset, it starts at sample index 0.
- R3: A piece ends `post_len` samples after the last sample above threshold.
- R4: Sample k is exported when some above-threshold sample lies between k-post_len and k+pre_len. Overlapping or touching regions therefore form one piece, and a region separated by at least one unexported sample forms its own piece.
- R5: No piece is longer than `max_len` samples. A kept sample that follows a full piece opens a new piece at once.
- R6: A header word has `m_hdr`=1 and `m_data` = {cont[1], channel[CHW], length[log2 FIFO_DEPTH], time tag[TSW]}, with the most significant field first. A sample word has `m_hdr`=0, the sample in `m_data[DW-1:0]`, and zeros above it.
- R7: The time tag is the index of the first sample of the piece. Samples are counted from 0 at reset, and only cycles with `s_valid` high count.
- R8: Words leave in time order, each header before its samples. A header is not presented until its piece is closed. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_hdr` and `m_data` hold.
- R9: Opening a piece needs two free FIFO entries and appending needs one. Free space is counted before the read at the same edge. A kept sample that finds no room is dropped, the open piece is closed, and `overflow` is set and stays set until reset.
- R10: The cont flag of a piece is 1 exactly when the previous input sample was also kept. This covers a piece cut by `max_len` and a piece cut by a drop.
- R11: During and right after reset, `m_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input sample strobe |
| s_data | input | DW | Input sample, unsigned |
| threshold | input | DW | Trigger level |
| pre_len | input | log2 HIST_DEPTH | Samples kept before the first crossing |
| post_len | input | log2 HIST_DEPTH | Samples kept after the last crossing |
| max_len | input | log2 FIFO_DEPTH | Maximum samples per piece, at least 1 |
| chan_id | input | CHW | Channel number put in headers |
| m_ready | input | 1 | Output ready |
| m_valid | output | 1 | Output word valid |
| m_hdr | output | 1 | Output word is a header |
| m_data | output | CHW+log2 FIFO_DEPTH+TSW+1 | Output word |
| overflow | output | 1 | Sticky flag set when a sample was dropped |

## Verification
The bench builds the block with a 16-entry history ring and a 32-entry output FIFO. A piece of up to 20 samples fits while the reader stalls part of the time. Holding ready low fills the FIFO within a few dozen samples, so drops, truncated pieces and continuation after a drop all come within reach in a short run. Under these settings a pre-trigger count of 4 against a cap of 20 also lets one run show merged windows, separate windows one sample apart, and a piece split by the length cap.

// File: rtl/snippet_capture.sv
module snippet_capture #(
  parameter int DW         = 14,
  parameter int CHW        = 8,
  parameter int TSW        = 48,
  parameter int HIST_DEPTH = 64,
  parameter int FIFO_DEPTH = 128
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  s_valid,
  input  logic [DW-1:0]                         s_data,
  input  logic [DW-1:0]                         threshold,
  input  logic [$clog2(HIST_DEPTH)-1:0]         pre_len,
  input  logic [$clog2(HIST_DEPTH)-1:0]         post_len,
  input  logic [$clog2(FIFO_DEPTH)-1:0]         max_len,
  input  logic [CHW-1:0]                        chan_id,
  input  logic                                  m_ready,
  output logic                                  m_valid,
  output logic                                  m_hdr,
  output logic [CHW+$clog2(FIFO_DEPTH)+TSW:0]   m_data,
  output logic                                  overflow
);
  localparam int HA = $clog2(HIST_DEPTH);
  localparam int FA = $clog2(FIFO_DEPTH);
  localparam int OW = CHW + FA + TSW + 1;

  logic [DW-1:0]  hist [HIST_DEPTH];
  logic [OW:0]    fifo [FIFO_DEPTH];

  logic [TSW-1:0] tcnt, last_hit, snip_ts;
  logic           seen_hit, in_snip, prev_keep, snip_cont, hdr_pend;
  logic [FA-1:0]  seg_len, wp, rp, hslot;
  logic [FA:0]    cnt;

  logic           above, hit_any, keep, full_len;
  logic           do_open, do_app, do_close, drop, pop;
  logic [TSW-1:0] hit_idx, d_idx;
  logic [HA-1:0]  hsel;
  logic [DW-1:0]  d_val;
  logic [1:0]     add;
  logic [FA-1:0]  wr_addr;
  logic [OW:0]    smp_word, hdr_word;

  assign above    = s_valid && (s_data > threshold);
  assign hit_idx  = above ? tcnt : last_hit;
  assign hit_any  = above || seen_hit;
  assign d_idx    = tcnt - TSW'(pre_len);
  assign keep     = s_valid && (tcnt >= TSW'(pre_len)) && hit_any &&
                    (({1'b0, hit_idx} + (TSW+1)'(post_len)) >= {1'b0, d_idx});
  assign hsel     = tcnt[HA-1:0] - pre_len;
  assign d_val    = (pre_len == '0) ? s_data : hist[hsel];

  assign full_len = in_snip && (seg_len == max_len);
  assign do_open  = keep && (!in_snip || full_len) && (cnt <= (FA+1)'(FIFO_DEPTH - 2));
  assign do_app   = keep && in_snip && !full_len && (cnt != (FA+1)'(FIFO_DEPTH));
  assign do_close = s_valid && in_snip && !do_app;
  assign drop     = keep && !do_open && !do_app;
  assign add      = do_open ? 2'd2 : (do_app ? 2'd1 : 2'd0);
  assign wr_addr  = do_open ? wp + FA'(1) : wp;

  assign smp_word = {1'b0, {(OW-DW){1'b0}}, d_val};
  assign hdr_word = {1'b1, snip_cont, chan_id, seg_len, snip_ts};

  assign m_valid  = (cnt != '0) && !(hdr_pend && (rp == hslot));
  assign m_hdr    = fifo[rp][OW];
  assign m_data   = fifo[rp][OW-1:0];
  assign pop      = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (s_valid) hist[tcnt[HA-1:0]] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (do_open || do_app) fifo[wr_addr] <= smp_word;
    if (do_close)          fifo[hslot]   <= hdr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt      <= '0;
      last_hit  <= '0;
      seen_hit  <= 1'b0;
      prev_keep <= 1'b0;
    end else if (s_valid) begin
      tcnt      <= tcnt + TSW'(1);
      last_hit  <= hit_idx;
      seen_hit  <= hit_any;
      prev_keep <= keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_snip   <= 1'b0;
      hdr_pend  <= 1'b0;
      snip_cont <= 1'b0;
      snip_ts   <= '0;
      seg_len   <= '0;
      hslot     <= '0;
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      overflow  <= 1'b0;
    end else begin
      if (do_open) begin
        in_snip   <= 1'b1;
        hdr_pend  <= 1'b1;
        hslot     <= wp;
        snip_ts   <= d_idx;
        snip_cont <= prev_keep;
        seg_len   <= FA'(1);
      end else if (do_app) begin
        seg_len   <= seg_len + FA'(1);
      end else if (do_close) begin
        in_snip   <= 1'b0;
        hdr_pend  <= 1'b0;
      end
      if (drop) overflow <= 1'b1;
      wp  <= wp + FA'(add);
      if (pop) rp <= rp + FA'(1);
      cnt <= cnt + (FA+1)'(add) - (FA+1)'(pop);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (FA+1)'(FIFO_DEPTH)); // R9
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_snip |-> (seg_len <= max_len) && (seg_len != '0)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_hdr)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(cnt) > (FA+1)'(FIFO_DEPTH - 2)); // R9
endmodule

// File: tb/snippet_capture_test.sv
module snippet_capture_test;
  localparam int DW = 14, CHW = 8, TSW = 48, HD = 16, FD = 32;
  localparam int HA = 4, FA = 5, OW = CHW + FA + TSW + 1;

  logic clk = 1'b0, rst_n = 1'b0, s_valid = 1'b0, m_ready = 1'b0;
  logic [DW-1:0] s_data = '0, threshold = '0;
  logic [HA-1:0] pre_len = '0, post_len = '0;
  logic [FA-1:0] max_len = '0;
  logic [CHW-1:0] chan_id = '0;
  logic m_valid, m_hdr, overflow;
  logic [OW-1:0] m_data;

  always #5 clk = ~clk;

  snippet_capture #(.DW(DW), .CHW(CHW), .TSW(TSW), .HIST_DEPTH(HD), .FIFO_DEPTH(FD)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .threshold(threshold),
    .pre_len(pre_len), .post_len(post_len), .max_len(max_len), .chan_id(chan_id),
    .m_ready(m_ready), .m_valid(m_valid), .m_hdr(m_hdr), .m_data(m_data), .overflow(overflow));

  int checks = 0, errors = 0, cyc = 0, rmode = 0;
  int pre, post, maxl, thr, chan;
  int smp[$];
  int m_L, m_len, m_ts, m_wr, m_rd, m_hslot;
  bit m_seen, m_in, m_prev, m_cont, m_pend;
  logic [OW:0] mq [int];
  int f_ts[$], f_len[$], f_cont[$], f_chan[$];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    smp.delete(); mq.delete();
    m_L = 0; m_len = 0; m_ts = 0; m_wr = 0; m_rd = 0; m_hslot = 0;
    m_seen = 0; m_in = 0; m_prev = 0; m_cont = 0; m_pend = 0;
  endtask

  task automatic close_hdr();
    mq[m_hslot] = {1'b1, m_cont, CHW'(chan), FA'(m_len), TSW'(m_ts)};
    m_pend = 0; m_in = 0;
  endtask

  function automatic bit exp_valid();
    return (m_wr - m_rd) > 0 && !(m_pend && m_rd == m_hslot);
  endfunction

  task automatic model_step(bit v, int data, bit rdy);
    int cnt;
    bit pop;
    cnt = m_wr - m_rd;
    pop = rdy && exp_valid();
    if (v) begin
      int t, d;
      bit keep, full;
      smp.push_back(data);
      t = smp.size() - 1;
      if (data > thr) begin m_L = t; m_seen = 1; end
      d = t - pre;
      keep = (d >= 0) && m_seen && (m_L + post >= d);
      full = m_in && (m_len == maxl);
      if (keep && (!m_in || full)) begin
        if (m_in) close_hdr();
        if (cnt <= FD - 2) begin
          m_hslot = m_wr; m_pend = 1;
          mq[m_wr + 1] = {1'b0, {(OW-DW){1'b0}}, DW'(smp[d])};
          m_wr += 2; m_in = 1; m_len = 1; m_ts = d; m_cont = m_prev;
        end
      end else if (keep) begin
        if (cnt < FD) begin
          mq[m_wr] = {1'b0, {(OW-DW){1'b0}}, DW'(smp[d])};
          m_wr += 1; m_len += 1;
        end else close_hdr();
      end else if (m_in) close_hdr();
      m_prev = keep;
    end
    if (pop) m_rd++;
  endtask

  task automatic tick(bit v, int data);
    bit ev;
    @(negedge clk);
    cyc++;
    ev = exp_valid();
    chk(m_valid === ev, "R8", "m_valid", 64'(m_valid), 64'(ev));
    if (ev && m_valid)
      chk({m_hdr, m_data} === mq[m_rd], mq[m_rd][OW] ? "R6" : "R8", "word",
          64'({m_hdr, m_data}), 64'(mq[m_rd]));
    s_valid = v;
    s_data = DW'(data);
    m_ready = (rmode == 0) || (rmode == 1 && (cyc % 4) != 0);
    if (m_valid && m_ready && m_hdr) begin
      f_ts.push_back(int'(m_data[TSW-1:0]));
      f_len.push_back(int'(m_data[TSW+FA-1:TSW]));
      f_chan.push_back(int'(m_data[TSW+FA+CHW-1:TSW+FA]));
      f_cont.push_back(int'(m_data[OW-1]));
    end
    model_step(v, data, m_ready);
  endtask

  task automatic feed(int val);
    if (cyc % 3 == 2) tick(1'b0, 0);
    tick(1'b1, val);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    threshold = DW'(thr); pre_len = HA'(pre); post_len = HA'(post);
    max_len = FA'(maxl); chan_id = CHW'(chan);
    repeat (2) @(negedge clk);
    chk(m_valid === 1'b0, "R11", "m_valid in reset", 64'(m_valid), 0);
    chk(overflow === 1'b0, "R11", "overflow in reset", 64'(overflow), 0);
    model_reset();
    f_ts.delete(); f_len.delete(); f_cont.delete(); f_chan.delete();
    rst_n = 1'b1;
  endtask

  function automatic int val1(int t);
    if (t == 10) return 100;
    if (t == 15 || t == 40 || t == 47 || t == 60 || t == 69) return 101 + t % 7;
    if (t >= 80 && t <= 109) return 200 + t % 5;
    return t % 50;
  endfunction

  task automatic frame_chk(int i, int ts, int len, int cont, string req);
    if (f_ts.size() > i) begin
      chk(f_ts[i] == ts, "R7", $sformatf("frame %0d time tag", i), 64'(f_ts[i]), 64'(ts));
      chk(f_len[i] == len, req, $sformatf("frame %0d length", i), 64'(f_len[i]), 64'(len));
      chk(f_cont[i] == cont, "R10", $sformatf("frame %0d cont", i), 64'(f_cont[i]), 64'(cont));
      chk(f_chan[i] == chan, "R6", $sformatf("frame %0d channel", i), 64'(f_chan[i]), 64'(chan));
    end else chk(1'b0, req, $sformatf("frame %0d missing", i), 64'(f_ts.size()), 64'(i + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pre = 4; post = 3; maxl = 20; thr = 100; chan = 5; rmode = 1;
    do_reset();
    @(negedge clk);
    chk(m_valid === 1'b0, "R11", "m_valid after reset", 64'(m_valid), 0);
    for (int t = 0; t < 130; t++) feed(val1(t));
    idle(60);
    chk(f_ts.size() == 6, "R1", "frame count, equal sample ignored", 64'(f_ts.size()), 6);
    chk(overflow === 1'b0, "R9", "no overflow under light stall", 64'(overflow), 0);
    frame_chk(0, 11, 8, 0, "R2");
    frame_chk(1, 36, 15, 0, "R4");
    frame_chk(2, 56, 8, 0, "R3");
    frame_chk(3, 65, 8, 0, "R4");
    frame_chk(4, 76, 20, 0, "R5");
    frame_chk(5, 96, 17, 1, "R5");

    pre = 2; post = 2; maxl = 12; thr = 100; chan = 9; rmode = 2;
    do_reset();
    for (int t = 0; t < 40; t++) feed(300);
    idle(2);
    chk(overflow === 1'b1, "R9", "overflow after stall", 64'(overflow), 1);
    chk(m_valid === 1'b1 && m_hdr === 1'b1, "R8", "header first while stalled",
        64'({m_valid, m_hdr}), 3);
    rmode = 1;
    idle(10);
    for (int t = 0; t < 3; t++) feed(300);
    for (int t = 0; t < 20; t++) feed(0);
    idle(80);
    chk(overflow === 1'b1, "R9", "overflow sticky", 64'(overflow), 1);
    chk(f_ts.size() == 4, "R9", "frame count after drop", 64'(f_ts.size()), 4);
    frame_chk(0, 0, 12, 0, "R5");
    frame_chk(1, 12, 12, 1, "R5");
    frame_chk(2, 24, 5, 1, "R9");
    frame_chk(3, 38, 7, 1, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule